// File: doc/BRIEF.md
# Four-Channel DAC Command Front End

This block sits between a byte-wide register bus and a four-channel digital-to-analog converter. Software places a value in two data bytes and then writes a command byte. The command's upper nibble picks an operation and its lower bits pick a target channel. Each channel keeps its span (output range) and its code (output value) in two stages. The input stage takes new values. The active stage is what the converter drives. Writes and updates are separate operations, so a new setting can be staged on several channels and then made active on all of them in one step.

A readback command copies one span or code, from either stage, into the data bytes so that the bus can read it back. Each accepted command clears the ready bit in the status register for a fixed number of clock cycles. While the bit is low, further command and data writes are ignored. Two instances placed four bytes apart give eight channels. The conversion itself lies outside this block.

Control is a three-state machine:
- IDLE: ready is high and bus writes are accepted. A command write moves it to EXEC.
- EXEC: lasts one cycle. The decoded operation is applied, and the machine moves to HOLD.
- HOLD: a counter runs down. When it reaches zero the machine returns to IDLE.

Top module: `dac_cmd_frontend`

## Requirements
- R1: After reset, every input-stage and active-stage span and code is zero, both data bytes are zero, the stored command is zero, and ready is high.
- R2: The local address selects the register. Address 0 is data low, 1 is data high, 2 is the command and 3 is status. A read of address 2 returns the last accepted command. A read of address 3 returns ready in bit 7 and zeros in the other bits.
- R3: Opcode 2 (command bits 7:4) writes data-low bits 3:0 into the target's input span. Opcode 3 writes {data high, data low} into the target's input code. Neither changes any active value.
- R4: Opcode 4 copies the input span and code of the target into its active stage. Opcode 5 does the same for every channel, whatever the channel field holds.
- R5: Opcodes 6 and 7 write span or code like opcodes 2 and 3, and the target's active stage then takes the newly written value in the same command.
- R6: Opcodes 8 and 9 write span or code into the target's input stage, then update the active stage of every channel.
- R7: Command bits 2:1 give the target channel, and bit 0 is ignored. A low nibble of 0xF targets all channels for writes and updates. A readback with low nibble 0xF reads channel 3.
- R8: Readback loads the 16-bit value into the data bytes, with a span zero-extended. Opcode 0xA reads the input span, 0xB the input code, 0xC the active span and 0xD the active code.
- R9: Opcodes 0, 1, 0xE and 0xF change no span, code or data byte, but they still clear ready.
- R10: After a command write is accepted, ready is low for exactly READY_LAT cycles and then returns high.
- R11: While ready is low, command writes and data-byte writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Local register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmd_ready | output | 1 | High when a new command may be written |
| act_span | output | NUM_CH x SPAN_W | Active span of each channel |
| act_code | output | NUM_CH x 2*BYTE_W | Active code of each channel |

## Verification
The bench sweeps all sixteen opcodes. Each opcode is sent against five channel-field values: one per channel, two of them with the ignored bit 0 set, plus the all-channel nibble. Every command carries fresh pseudo-random data bytes. After each command the bench compares all active outputs and the data bytes with an arithmetic model. This separates a write that wrongly reaches the active stage from one that correctly waits for an update, and a single-channel update from a broadcast. The all-channel pattern separates broadcast writes from readback of channel 3. Separate sequences measure the exact length of the ready-low window and send command and data writes during that window to show they are dropped.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_HOLD = 2'd2
    } fe_state_e;

    localparam logic [3:0] OP_WSPAN      = 4'h2;
    localparam logic [3:0] OP_WCODE      = 4'h3;
    localparam logic [3:0] OP_UPD        = 4'h4;
    localparam logic [3:0] OP_UPD_ALL    = 4'h5;
    localparam logic [3:0] OP_WSPAN_UPD  = 4'h6;
    localparam logic [3:0] OP_WCODE_UPD  = 4'h7;
    localparam logic [3:0] OP_WSPAN_UALL = 4'h8;
    localparam logic [3:0] OP_WCODE_UALL = 4'h9;
    localparam logic [3:0] OP_RD_IN_SPAN = 4'hA;
    localparam logic [3:0] OP_RD_IN_CODE = 4'hB;
    localparam logic [3:0] OP_RD_AC_SPAN = 4'hC;
    localparam logic [3:0] OP_RD_AC_CODE = 4'hD;

    typedef struct packed {
        logic wr_span;
        logic wr_code;
        logic upd_tgt;
        logic upd_all;
        logic rd_en;
        logic rd_active;
        logic rd_code;
    } fe_dec_t;

endpackage

// File: rtl/dacfe_decode.sv
module dacfe_decode
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 4,
    localparam int CH_W = $clog2(NUM_CH)
) (
    input  logic [7:0]        cmd,
    output fe_dec_t           dec,
    output logic [NUM_CH-1:0] tgt_mask,
    output logic [CH_W-1:0]   rd_ch
);
    logic [3:0] op;

    always_comb begin
        op  = cmd[7:4];
        dec = '0;
        unique case (op)
            OP_WSPAN:      dec.wr_span = 1'b1;
            OP_WCODE:      dec.wr_code = 1'b1;
            OP_UPD:        dec.upd_tgt = 1'b1;
            OP_UPD_ALL:    dec.upd_all = 1'b1;
            OP_WSPAN_UPD:  begin dec.wr_span = 1'b1; dec.upd_tgt = 1'b1; end
            OP_WCODE_UPD:  begin dec.wr_code = 1'b1; dec.upd_tgt = 1'b1; end
            OP_WSPAN_UALL: begin dec.wr_span = 1'b1; dec.upd_all = 1'b1; end
            OP_WCODE_UALL: begin dec.wr_code = 1'b1; dec.upd_all = 1'b1; end
            OP_RD_IN_SPAN: dec.rd_en = 1'b1;
            OP_RD_IN_CODE: begin dec.rd_en = 1'b1; dec.rd_code = 1'b1; end
            OP_RD_AC_SPAN: begin dec.rd_en = 1'b1; dec.rd_active = 1'b1; end
            OP_RD_AC_CODE: begin
                dec.rd_en     = 1'b1;
                dec.rd_active = 1'b1;
                dec.rd_code   = 1'b1;
            end
            default:       dec = '0;
        endcase
    end

    always_comb begin
        rd_ch = cmd[CH_W:1];
        if (cmd[3:0] == 4'hF) tgt_mask = '1;
        else                  tgt_mask = NUM_CH'(1) << rd_ch;
    end

endmodule

// File: rtl/dacfe_chan_bank.sv
module dacfe_chan_bank
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SPAN_W = 4,
    parameter int CODE_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           apply,
    input  fe_dec_t                        dec,
    input  logic [NUM_CH-1:0]              tgt_mask,
    input  logic [SPAN_W-1:0]              new_span,
    input  logic [CODE_W-1:0]              new_code,
    output logic [NUM_CH-1:0][SPAN_W-1:0]  in_span,
    output logic [NUM_CH-1:0][CODE_W-1:0]  in_code,
    output logic [NUM_CH-1:0][SPAN_W-1:0]  ac_span,
    output logic [NUM_CH-1:0][CODE_W-1:0]  ac_code
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic              wr_s, wr_c, upd;
        logic [SPAN_W-1:0] nxt_span;
        logic [CODE_W-1:0] nxt_code;

        always_comb begin
            wr_s     = apply && dec.wr_span && tgt_mask[i];
            wr_c     = apply && dec.wr_code && tgt_mask[i];
            upd      = apply && ((dec.upd_tgt && tgt_mask[i]) || dec.upd_all);
            nxt_span = wr_s ? new_span : in_span[i];
            nxt_code = wr_c ? new_code : in_code[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_span[i] <= '0;
                in_code[i] <= '0;
                ac_span[i] <= '0;
                ac_code[i] <= '0;
            end else begin
                in_span[i] <= nxt_span;
                in_code[i] <= nxt_code;
                if (upd) begin
                    ac_span[i] <= nxt_span;
                    ac_code[i] <= nxt_code;
                end
            end
        end
    end

endmodule

// File: rtl/dac_cmd_frontend.sv
module dac_cmd_frontend
    import dacfe_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int SPAN_W    = 4,
    parameter int BYTE_W    = 8,
    parameter int READY_LAT = 4,
    localparam int CODE_W = 2 * BYTE_W,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int CNT_W  = (READY_LAT > 2) ? $clog2(READY_LAT) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [1:0]                    bus_addr,
    input  logic [BYTE_W-1:0]             bus_wdata,
    output logic [BYTE_W-1:0]             bus_rdata,
    output logic                          cmd_ready,
    output logic [NUM_CH-1:0][SPAN_W-1:0] act_span,
    output logic [NUM_CH-1:0][CODE_W-1:0] act_code
);
    localparam logic [1:0] A_DLO  = 2'd0;
    localparam logic [1:0] A_DHI  = 2'd1;
    localparam logic [1:0] A_CMD  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    fe_state_e                     state, state_nx;
    logic [CNT_W-1:0]              hold_cnt;
    logic [BYTE_W-1:0]             cmd_q, data_lo, data_hi;
    logic                          exec_now, idle_now;
    fe_dec_t                       dec;
    logic [NUM_CH-1:0]             tgt_mask;
    logic [CH_W-1:0]               rd_ch;
    logic [NUM_CH-1:0][SPAN_W-1:0] in_span;
    logic [NUM_CH-1:0][CODE_W-1:0] in_code;
    logic [CODE_W-1:0]             rb_val;

    dacfe_decode #(.NUM_CH(NUM_CH)) u_dec (
        .cmd      (cmd_q),
        .dec      (dec),
        .tgt_mask (tgt_mask),
        .rd_ch    (rd_ch)
    );

    dacfe_chan_bank #(
        .NUM_CH (NUM_CH),
        .SPAN_W (SPAN_W),
        .CODE_W (CODE_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .apply    (exec_now),
        .dec      (dec),
        .tgt_mask (tgt_mask),
        .new_span (data_lo[SPAN_W-1:0]),
        .new_code ({data_hi, data_lo}),
        .in_span  (in_span),
        .in_code  (in_code),
        .ac_span  (act_span),
        .ac_code  (act_code)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (bus_wr && bus_addr == A_CMD) state_nx = ST_EXEC;
            ST_EXEC: state_nx = ST_HOLD;
            ST_HOLD: if (hold_cnt == '0) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and mux
    always_comb begin
        idle_now  = (state == ST_IDLE);
        exec_now  = (state == ST_EXEC);
        cmd_ready = idle_now;
        if (dec.rd_code)
            rb_val = dec.rd_active ? act_code[rd_ch] : in_code[rd_ch];
        else
            rb_val = CODE_W'(dec.rd_active ? act_span[rd_ch] : in_span[rd_ch]);
        unique case (bus_addr)
            A_DLO:   bus_rdata = data_lo;
            A_DHI:   bus_rdata = data_hi;
            A_CMD:   bus_rdata = cmd_q;
            A_STAT:  bus_rdata = {idle_now, {(BYTE_W-1){1'b0}}};
            default: bus_rdata = '0;
        endcase
    end

    // hold counter and bus registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            cmd_q    <= '0;
            data_lo  <= '0;
            data_hi  <= '0;
        end else begin
            if (exec_now)
                hold_cnt <= CNT_W'(READY_LAT - 2);
            else if (state == ST_HOLD && hold_cnt != '0)
                hold_cnt <= hold_cnt - 1'b1;

            if (idle_now && bus_wr) begin
                if (bus_addr == A_DLO) data_lo <= bus_wdata;
                if (bus_addr == A_DHI) data_hi <= bus_wdata;
                if (bus_addr == A_CMD) cmd_q   <= bus_wdata;
            end else if (exec_now && dec.rd_en) begin
                data_lo <= rb_val[BYTE_W-1:0];
                data_hi <= rb_val[CODE_W-1:BYTE_W];
            end
        end
    end

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
    parameter int NUM_CH = 4,
    parameter int SPAN_W = 4,
    parameter int BYTE_W = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            bus_wr,
    input logic [1:0]                      bus_addr,
    input logic [BYTE_W-1:0]               bus_rdata,
    input logic                            cmd_ready,
    input logic                            exec_now,
    input logic [BYTE_W-1:0]               data_lo,
    input logic [BYTE_W-1:0]               data_hi,
    input logic [BYTE_W-1:0]               cmd_q,
    input logic [NUM_CH-1:0][SPAN_W-1:0]   act_span,
    input logic [NUM_CH-1:0][2*BYTE_W-1:0] act_code
);
    a_r10_cmd_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && cmd_ready) |=> (!cmd_ready && exec_now));

    a_r10_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        exec_now |=> (!exec_now && !cmd_ready));

    a_r4_active_only_on_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_now |=> ($stable(act_span) && $stable(act_code)));

    a_r11_busy_holds_regs: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && !exec_now) |=> ($stable(data_lo) && $stable(data_hi) && $stable(cmd_q)));

    a_r2_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == {cmd_ready, {(BYTE_W-1){1'b0}}}));

endmodule

bind dac_cmd_frontend dacfe_checker #(
    .NUM_CH (NUM_CH),
    .SPAN_W (SPAN_W),
    .BYTE_W (BYTE_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cmd_ready (cmd_ready),
    .exec_now  (exec_now),
    .data_lo   (data_lo),
    .data_hi   (data_hi),
    .cmd_q     (cmd_q),
    .act_span  (act_span),
    .act_code  (act_code)
);

// File: tb/test_dac_cmd_frontend.sv
module test_dac_cmd_frontend;
    localparam int LAT = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [7:0]       bus_wdata = 8'd0;
    logic [7:0]       bus_rdata;
    logic             cmd_ready;
    logic [3:0][3:0]  act_span;
    logic [3:0][15:0] act_code;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [3:0]  m_in_span [4];
    logic [15:0] m_in_code [4];
    logic [3:0]  m_ac_span [4];
    logic [15:0] m_ac_code [4];
    logic [7:0]  m_lo, m_hi, m_cmd;
    logic [15:0] lfsr = 16'hACE1;

    dac_cmd_frontend #(.READY_LAT(LAT)) i_dac_cmd_frontend (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmd_ready (cmd_ready),
        .act_span  (act_span),
        .act_code  (act_code)
    );

    always #2.5 clk = ~clk;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cycles);
                finish_run();
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_ready();
        while (!cmd_ready) @(negedge clk);
    endtask

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'h2, 4'h3: return "R3";
            4'h4, 4'h5: return "R4";
            4'h6, 4'h7: return "R5";
            4'h8, 4'h9: return "R6";
            4'hA, 4'hB, 4'hC, 4'hD: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic model(logic [3:0] op, logic [3:0] nib, logic [7:0] lo, logic [7:0] hi);
        logic [1:0]  ch = nib[2:1];
        logic        ws = (op == 4'h2 || op == 4'h6 || op == 4'h8);
        logic        wc = (op == 4'h3 || op == 4'h7 || op == 4'h9);
        logic        ut = (op == 4'h4 || op == 4'h6 || op == 4'h7);
        logic        ua = (op == 4'h5 || op == 4'h8 || op == 4'h9);
        logic [15:0] rb;
        m_cmd = {op, nib};
        m_lo = lo;
        m_hi = hi;
        for (int i = 0; i < 4; i++) begin
            logic tg = (nib == 4'hF) || (i == int'(ch));
            if (ws && tg) m_in_span[i] = lo[3:0];
            if (wc && tg) m_in_code[i] = {hi, lo};
            if (ua || (ut && tg)) begin
                m_ac_span[i] = m_in_span[i];
                m_ac_code[i] = m_in_code[i];
            end
        end
        rb = 16'h0;
        case (op)
            4'hA: rb = {12'h0, m_in_span[ch]};
            4'hB: rb = m_in_code[ch];
            4'hC: rb = {12'h0, m_ac_span[ch]};
            4'hD: rb = m_ac_code[ch];
            default: rb = {hi, lo};
        endcase
        m_lo = rb[7:0];
        m_hi = rb[15:8];
    endtask

    task automatic check_all(string tag);
        logic [7:0] d0, d1, dc;
        for (int i = 0; i < 4; i++)
            chk($sformatf("%s ch%0d", tag, i), {12'h0, act_span[i], act_code[i]},
                {12'h0, m_ac_span[i], m_ac_code[i]});
        bus_read(2'd0, d0);
        bus_read(2'd1, d1);
        bus_read(2'd2, dc);
        chk($sformatf("%s data/cmd bytes", tag), {8'h0, dc, d1, d0}, {8'h0, m_cmd, m_hi, m_lo});
    endtask

    task automatic do_cmd(logic [3:0] op, logic [3:0] nib, logic [7:0] lo, logic [7:0] hi);
        bus_write(2'd0, lo);
        bus_write(2'd1, hi);
        bus_write(2'd2, {op, nib});
        model(op, nib, lo, hi);
        wait_ready();
        check_all($sformatf("%s op%h nib%h", tag_of(op), op, nib));
    endtask

    function automatic logic [15:0] step(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        logic [7:0] rd;
        logic [3:0] nibs [5] = '{4'h0, 4'h3, 4'h4, 4'h7, 4'hF};
        for (int i = 0; i < 4; i++) begin
            m_in_span[i] = '0; m_in_code[i] = '0;
            m_ac_span[i] = '0; m_ac_code[i] = '0;
        end
        m_lo = '0; m_hi = '0; m_cmd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 ready", {31'h0, cmd_ready}, 32'h1);
        check_all("R1 reset");
        // R2 status register
        bus_read(2'd3, rd);
        chk("R2 status idle", {24'h0, rd}, 32'h80);

        // R10 exact ready-low window
        begin
            int n = 0;
            bus_write(2'd0, 8'h05);
            bus_write(2'd1, 8'h00);
            bus_write(2'd2, 8'h2F);
            model(4'h2, 4'hF, 8'h05, 8'h00);
            bus_addr = 2'd3;
            #1 chk("R2 status busy", {24'h0, bus_rdata}, 32'h0);
            while (!cmd_ready && n < 100) begin
                n++;
                @(negedge clk);
            end
            chk("R10 ready low cycles", n, LAT);
            check_all("R10 after window");
        end

        // R11 writes while busy are dropped
        bus_write(2'd0, 8'h11);
        bus_write(2'd1, 8'h22);
        bus_write(2'd2, 8'h70);
        model(4'h7, 4'h0, 8'h11, 8'h22);
        bus_write(2'd0, 8'h99);
        bus_write(2'd2, 8'h32);
        wait_ready();
        check_all("R11 busy writes ignored");

        // R3-R9 sweep of every opcode against five channel fields
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 5; k++) begin
                lfsr = step(lfsr);
                lfsr = step(lfsr);
                do_cmd(4'(op), nibs[k], lfsr[7:0], lfsr[15:8]);
            end
        end

        // R7 broadcast writes then single updates, readback of channel 3 via 0xF
        do_cmd(4'h3, 4'hF, 8'h5A, 8'hC3);
        do_cmd(4'h4, 4'h2, 8'h00, 8'h00);
        do_cmd(4'hB, 4'hF, 8'h00, 8'h00);
        do_cmd(4'hD, 4'h2, 8'h00, 8'h00);

        finish_run();
    end

endmodule